// File: doc/BRIEF.md
# Double to Signed Integer Converter

This block turns a 64-bit IEEE binary floating-point operand into a signed integer of 16, 32 or 64 bits. The rounding direction comes from a two-bit field inside a 16-bit control word. Four directions are available: nearest with ties to even, toward minus infinity, toward plus infinity, and toward zero. The result is returned sign-extended to 64 bits, together with an invalid flag.

The converter takes one operand per cycle when `in_valid` is high. It delivers the result one clock later with `out_valid`. An operand that is NaN, an infinity, or a value that falls outside the target range after rounding does not produce a converted number. It returns the integer-indefinite pattern for the selected size instead, which is the most negative value of that size, and it raises the invalid flag.

Top module: `fp2int_cvt`

## Requirements
- R1: After reset, `out_valid` is low. An accepted operand (`in_valid` high at a rising edge) produces `out_valid` high one cycle later. A cycle without `in_valid` produces `out_valid` low one cycle later, and `out_result` and `out_invalid` keep their previous values.
- R2: The rounding mode is taken only from `in_ctrl[11:10]`. The other control bits have no effect on the result or on the flag.
- R3: Mode 0 rounds to the nearest integer. A value exactly halfway between two integers goes to the even one.
- R4: Mode 1 rounds toward minus infinity (floor).
- R5: Mode 2 rounds toward plus infinity (ceiling).
- R6: Mode 3 rounds toward zero. A positive value takes the floor and any other value takes the ceiling.
- R7: `in_size` selects the target width. 0 selects 16 bits, 1 selects 32 bits, and 2 or 3 selects 64 bits. A valid result is sign-extended to 64 bits.
- R8: The range check applies to the rounded value. A value that rounds into [-2^(N-1), 2^(N-1)-1] is accepted, and a value that rounds outside it is rejected.
- R9: A rejected value yields `out_invalid`=1 and `out_result` = -2^(N-1) sign-extended to 64 bits (0xFFFF_FFFF_FFFF_8000, 0xFFFF_FFFF_8000_0000 or 0x8000_0000_0000_0000).
- R10: A NaN operand (exponent field all ones, fraction nonzero) yields the indefinite pattern and `out_invalid`=1 for every size.
- R11: Plus or minus infinity (exponent all ones, fraction zero) yields the indefinite pattern and `out_invalid`=1 for every size.
- R12: Negative zero converts to 0. Subnormal operands (exponent field zero) convert to 0, +1 or -1 according to the rounding mode, and never raise `out_invalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| in_operand | input | 64 | IEEE double-precision operand |
| in_ctrl | input | 16 | Control word; bits 11:10 give the rounding mode |
| in_size | input | 2 | Target width select: 0=16, 1=32, 2 or 3=64 |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | 64 | Signed integer result, sign-extended |
| out_invalid | output | 1 | NaN, infinity or out-of-range operand |

## Verification
Rounding and the range check can act on the same operand in one cycle. A rounding increment can carry a value across the target limit, and ties-to-even can keep a value just inside the negative limit. The bench provokes this with halfway and near-limit values such as 32767.5, -32768.5 and 2147483647.5, run under every mode and size. It also includes random operands whose exponents cluster near the 16, 32 and 64-bit boundaries. Each result and flag is judged against a bench model that rounds in floating point and applies the limits afterwards.

// File: rtl/fp2int_pkg.sv
package fp2int_pkg;
    localparam int FP_W   = 64;
    localparam int EXP_W  = 11;
    localparam int FRAC_W = 52;
    localparam int MANT_W = FRAC_W + 1;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int EXPU_W = EXP_W + 2;
    localparam int INT_W  = 64;
    localparam int FR_W   = INT_W + 2;
    localparam int SH_W   = $clog2(FR_W);
    localparam int CTRL_W = 16;
    localparam int RC_LSB = 10;
    localparam int N_SZ   = 3;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'd0,
        RM_DOWN    = 2'd1,
        RM_UP      = 2'd2,
        RM_ZERO    = 2'd3
    } rmode_e;

    typedef struct packed {
        logic             valid;
        logic             invalid;
        logic [INT_W-1:0] result;
    } cvt_state_t;
endpackage

// File: rtl/fp2int_unpack.sv
module fp2int_unpack
    import fp2int_pkg::*;
(
    input  logic [FP_W-1:0]          op,
    output logic                     sign,
    output logic                     is_nan,
    output logic                     is_inf,
    output logic signed [EXPU_W-1:0] exp_unb,
    output logic [MANT_W-1:0]        mant
);
    localparam logic signed [EXPU_W-1:0] BIAS_S = EXPU_W'(BIAS);
    localparam logic signed [EXPU_W-1:0] ONE_S  = EXPU_W'(1);

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_zero;
    logic              exp_max;

    always_comb begin
        sign     = op[FP_W-1];
        exp_f    = op[FP_W-2 -: EXP_W];
        frac_f   = op[FRAC_W-1:0];
        exp_zero = (exp_f == '0);
        exp_max  = &exp_f;
        is_nan   = exp_max && (frac_f != '0);
        is_inf   = exp_max && (frac_f == '0);
        mant     = {~exp_zero, frac_f};
        exp_unb  = exp_zero ? (ONE_S - BIAS_S)
                            : ($signed({2'b00, exp_f}) - BIAS_S);
    end
endmodule

// File: rtl/fp2int_align.sv
module fp2int_align
    import fp2int_pkg::*;
(
    input  logic [MANT_W-1:0]        mant,
    input  logic signed [EXPU_W-1:0] exp_unb,
    output logic [INT_W-1:0]         int_part,
    output logic                     rbit,
    output logic                     sticky,
    output logic                     too_big
);
    localparam int WIDE_W = INT_W + FR_W;
    localparam logic signed [EXPU_W-1:0] TOP_S = EXPU_W'(INT_W - 1);
    localparam logic signed [EXPU_W-1:0] MAXSH = EXPU_W'(FR_W - 1);

    logic signed [EXPU_W-1:0] amt_s;
    logic [SH_W-1:0]          amt;
    logic [WIDE_W-1:0]        wide;

    always_comb begin
        too_big = (exp_unb > TOP_S);
        amt_s   = TOP_S - exp_unb;
        if (amt_s < 0)
            amt = '0;
        else if (amt_s > MAXSH)
            amt = SH_W'(FR_W - 1);
        else
            amt = amt_s[SH_W-1:0];
        wide     = {mant, {(INT_W - MANT_W){1'b0}}, {FR_W{1'b0}}} >> amt;
        int_part = wide[WIDE_W-1 -: INT_W];
        rbit     = wide[FR_W-1];
        sticky   = |wide[FR_W-2:0];
    end
endmodule

// File: rtl/fp2int_round.sv
module fp2int_round
    import fp2int_pkg::*;
(
    input  logic [INT_W-1:0] int_part,
    input  logic             rbit,
    input  logic             sticky,
    input  logic             sign,
    input  rmode_e           rmode,
    output logic [INT_W:0]   mag
);
    logic inexact;
    logic inc;

    always_comb begin
        inexact = rbit | sticky;
        unique case (rmode)
            RM_NEAREST: inc = rbit & (sticky | int_part[0]);
            RM_DOWN:    inc = sign & inexact;
            RM_UP:      inc = ~sign & inexact;
            default:    inc = 1'b0;
        endcase
        mag = {1'b0, int_part} + {{INT_W{1'b0}}, inc};
    end
endmodule

// File: rtl/fp2int_range.sv
module fp2int_range
    import fp2int_pkg::*;
(
    input  logic [INT_W:0]   mag,
    input  logic             sign,
    input  logic             too_big,
    input  logic             is_nan,
    input  logic             is_inf,
    input  logic [1:0]       size,
    output logic [INT_W-1:0] result,
    output logic             invalid
);
    logic [N_SZ-1:0]  ovf;
    logic [INT_W-1:0] indef [N_SZ];
    logic [1:0]       sel;
    logic [INT_W-1:0] signed_val;

    for (genvar i = 0; i < N_SZ; i++) begin : g_size
        localparam int W = 16 << i;
        logic pos_ovf;
        logic neg_ovf;
        always_comb begin
            pos_ovf  = |mag[INT_W:W-1];
            neg_ovf  = (|mag[INT_W:W]) | (mag[W-1] & (|mag[W-2:0]));
            ovf[i]   = sign ? neg_ovf : pos_ovf;
            indef[i] = {{(INT_W - W + 1){1'b1}}, {(W - 1){1'b0}}};
        end
    end

    always_comb begin
        unique case (size)
            2'd0:    sel = 2'd0;
            2'd1:    sel = 2'd1;
            default: sel = 2'd2;
        endcase
        signed_val = sign ? (~mag[INT_W-1:0] + 1'b1) : mag[INT_W-1:0];
        invalid    = is_nan | is_inf | too_big | ovf[sel];
        result     = invalid ? indef[sel] : signed_val;
    end
endmodule

// File: rtl/fp2int_cvt.sv
module fp2int_cvt
    import fp2int_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [FP_W-1:0]   in_operand,
    input  logic [CTRL_W-1:0] in_ctrl,
    input  logic [1:0]        in_size,
    output logic              out_valid,
    output logic [INT_W-1:0]  out_result,
    output logic              out_invalid
);
    logic                     sign;
    logic                     is_nan;
    logic                     is_inf;
    logic signed [EXPU_W-1:0] exp_unb;
    logic [MANT_W-1:0]        mant;
    logic [INT_W-1:0]         int_part;
    logic                     rbit;
    logic                     sticky;
    logic                     too_big;
    logic [INT_W:0]           mag;
    logic [INT_W-1:0]         conv_result;
    logic                     conv_invalid;
    rmode_e                   rmode;
    cvt_state_t               state_d;
    cvt_state_t               state_q;

    assign rmode = rmode_e'(in_ctrl[RC_LSB+1:RC_LSB]);

    fp2int_unpack u_unpack (
        .op      (in_operand),
        .sign    (sign),
        .is_nan  (is_nan),
        .is_inf  (is_inf),
        .exp_unb (exp_unb),
        .mant    (mant)
    );

    fp2int_align u_align (
        .mant     (mant),
        .exp_unb  (exp_unb),
        .int_part (int_part),
        .rbit     (rbit),
        .sticky   (sticky),
        .too_big  (too_big)
    );

    fp2int_round u_round (
        .int_part (int_part),
        .rbit     (rbit),
        .sticky   (sticky),
        .sign     (sign),
        .rmode    (rmode),
        .mag      (mag)
    );

    fp2int_range u_range (
        .mag     (mag),
        .sign    (sign),
        .too_big (too_big),
        .is_nan  (is_nan),
        .is_inf  (is_inf),
        .size    (in_size),
        .result  (conv_result),
        .invalid (conv_invalid)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = in_valid;
        if (in_valid) begin
            state_d.result  = conv_result;
            state_d.invalid = conv_invalid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign out_valid   = state_q.valid;
    assign out_result  = state_q.result;
    assign out_invalid = state_q.invalid;

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r1_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_invalid)));

    a_r10_nan_32: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (&in_operand[62:52]) && (|in_operand[51:0]) && in_size == 2'd1)
        |=> (out_invalid && out_result == 64'hFFFF_FFFF_8000_0000));

    a_r11_inf_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (&in_operand[62:52]) && in_operand[51:0] == '0) |=> out_invalid);

    a_r12_subnormal_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_operand[62:52] == '0) |=> !out_invalid);

    a_r9_indef_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_invalid) |-> (out_result[63] &&
        ($countones(out_result) == 49 || $countones(out_result) == 33 ||
         $countones(out_result) == 1)));

    a_r7_sext16: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_size == 2'd0) |=>
        ((&out_result[63:15]) || !(|out_result[63:15])));
endmodule

// File: tb/fp2int_cvt_tb.sv
`timescale 1ns/1ps
module fp2int_cvt_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_operand = '0;
    logic [15:0] in_ctrl = '0;
    logic [1:0]  in_size = '0;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_invalid;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    fp2int_cvt u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_operand  (in_operand),
        .in_ctrl     (in_ctrl),
        .in_size     (in_size),
        .out_valid   (out_valid),
        .out_result  (out_result),
        .out_invalid (out_invalid)
    );

    function automatic void ref_model(input logic [63:0] op, input logic [1:0] rm,
                                      input logic [1:0] sz, output logic [63:0] res,
                                      output logic inv);
        real x, fl, fr, r, lim;
        int  w;
        w   = (sz == 2'd0) ? 16 : (sz == 2'd1) ? 32 : 64;
        res = ~64'd0 << (w - 1);
        inv = 1'b1;
        if (op[62:52] == 11'h7FF) return;
        x  = $bitstoreal(op);
        fl = $floor(x);
        case (rm)
            2'd0: begin
                fr = x - fl;
                if (fr > 0.5)      r = fl + 1.0;
                else if (fr < 0.5) r = fl;
                else               r = ($floor(fl / 2.0) * 2.0 == fl) ? fl : fl + 1.0;
            end
            2'd1:    r = fl;
            2'd2:    r = $ceil(x);
            default: r = (x > 0.0) ? fl : $ceil(x);
        endcase
        lim = 1.0;
        for (int k = 0; k < w - 1; k++) lim = lim * 2.0;
        if (r >= lim || r < -lim) return;
        res = longint'(r);
        inv = 1'b0;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic run(input logic [63:0] op, input logic [15:0] ctrl,
                       input logic [1:0] sz, input string tag);
        logic [63:0] er;
        logic        ei;
        ref_model(op, ctrl[11:10], sz, er, ei);
        in_valid   = 1'b1;
        in_operand = op;
        in_ctrl    = ctrl;
        in_size    = sz;
        @(negedge clk);
        chk(out_valid == 1'b1, {tag, " valid"}, {63'd0, out_valid}, 64'd1);
        chk(out_result == er, {tag, " result"}, out_result, er);
        chk(out_invalid == ei, {tag, " flag"}, {63'd0, out_invalid}, {63'd0, ei});
    endtask

    function automatic logic [15:0] mode(input int m);
        return 16'(m) << 10;
    endfunction

    function automatic logic [63:0] rand_op();
        logic [63:0] v;
        int          c;
        int          k;
        c = int'($urandom % 4);
        v = {$urandom, $urandom};
        case (c)
            0: v[62:52] = 11'(1021 + $urandom % 70);
            1: begin
                k = int'($urandom % 140000) - 70000;
                v = $realtobits(real'(k) + 0.5);
            end
            2: v[62:52] = 11'(1036 + $urandom % 52);
            default: v[62:52] = ($urandom % 2 == 0) ? 11'd0 : 11'(1023 + $urandom % 16);
        endcase
        return v;
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] hold_r;
        logic        hold_i;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0 && out_result == '0 && out_invalid == 1'b0,
            "R1 reset state", out_result, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 nearest, ties to even
        run($realtobits(2.5),  mode(0), 2'd1, "R3 2.5");
        run($realtobits(3.5),  mode(0), 2'd1, "R3 3.5");
        run($realtobits(-2.5), mode(0), 2'd1, "R3 -2.5");
        run($realtobits(2.6),  mode(0), 2'd1, "R3 2.6");
        // R4 floor
        run($realtobits(-2.1), mode(1), 2'd1, "R4 -2.1");
        run($realtobits(2.9),  mode(1), 2'd1, "R4 2.9");
        // R5 ceiling
        run($realtobits(2.1),  mode(2), 2'd1, "R5 2.1");
        run($realtobits(-2.9), mode(2), 2'd1, "R5 -2.9");
        // R6 toward zero
        run($realtobits(2.9),  mode(3), 2'd1, "R6 2.9");
        run($realtobits(-2.9), mode(3), 2'd1, "R6 -2.9");
        // R2 unrelated control bits ignored
        run($realtobits(2.5),  16'hF3FF, 2'd1, "R2 mode0 noisy");
        run($realtobits(-2.9), 16'hFFFF, 2'd0, "R2 mode3 noisy");
        // R7 size select
        run($realtobits(100000.0), mode(0), 2'd0, "R7 16bit");
        run($realtobits(-100000.0), mode(0), 2'd1, "R7 32bit");
        run($realtobits(-100000.0), mode(0), 2'd3, "R7 size3");
        // R8 range after rounding
        run($realtobits(32767.4),  mode(0), 2'd0, "R8 32767.4");
        run($realtobits(32767.5),  mode(0), 2'd0, "R8 32767.5");
        run($realtobits(32767.5),  mode(1), 2'd0, "R8 32767.5 floor");
        run($realtobits(-32768.5), mode(0), 2'd0, "R8 -32768.5");
        run($realtobits(-32768.5), mode(1), 2'd0, "R8 -32768.5 floor");
        run($realtobits(2147483647.5), mode(2), 2'd1, "R8 32bit ceil");
        run($realtobits(-2147483648.9), mode(3), 2'd1, "R8 32bit trunc");
        // R9 64-bit limits
        run(64'h43E0_0000_0000_0000, mode(0), 2'd2, "R9 2^63");
        run(64'hC3E0_0000_0000_0000, mode(0), 2'd2, "R9 -2^63");
        run(64'h47F0_0000_0000_0000, mode(0), 2'd2, "R9 huge");
        // R10 NaN
        for (int s = 0; s < 3; s++)
            run(64'h7FF8_0000_0000_0001, mode(s), 2'(s), "R10 nan");
        // R11 infinities
        run(64'h7FF0_0000_0000_0000, mode(0), 2'd2, "R11 +inf");
        run(64'hFFF0_0000_0000_0000, mode(1), 2'd0, "R11 -inf");
        // R12 zero and subnormals
        run(64'h8000_0000_0000_0000, mode(0), 2'd1, "R12 -0");
        run(64'h0000_0000_0000_0001, mode(2), 2'd0, "R12 sub up");
        run(64'h8000_0000_0000_0001, mode(1), 2'd2, "R12 sub down");
        run(64'h8000_0000_0000_0001, mode(0), 2'd2, "R12 sub near");
        run(64'h8000_0000_0000_0001, mode(2), 2'd1, "R12 sub neg up");

        // R1 idle cycle: no valid, outputs held
        hold_r     = out_result;
        hold_i     = out_invalid;
        in_valid   = 1'b0;
        in_operand = 64'h7FF8_0000_0000_0000;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 idle valid", {63'd0, out_valid}, 64'd0);
        chk(out_result == hold_r && out_invalid == hold_i, "R1 idle hold",
            out_result, hold_r);

        // random mix over all requirements R3-R12
        for (int n = 0; n < 3000; n++)
            run(rand_op(), 16'($urandom), 2'($urandom), "R3-mix random");

        in_valid = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule